// File: doc/BRIEF.md
# Segmented Current-Steering Converter Front End

This block is the clocked digital front end of a 12-bit current-steering converter. A parallel code word enters on every rising clock edge, passes a two-stage register pipeline, and leaves as a set of switch controls for the steered current cells. The upper five bits of the code are expanded into a thermometer of 31 unit segments of equal weight. The lower seven bits drive seven binary-weighted lines directly. That makes 38 switch controls.

The analog cells are not part of the block. Each output leg is reported as an integer weight in LSB units, so the transfer function can be checked in a purely digital environment. A sleep control silences every switch and both weights. It also freezes the pipeline, so the stream picks up where it stopped when sleep is released. A synchronous active-low reset clears both pipeline stages to code zero.

Top module: `segdac_front`

## Requirements
- R1: A word present on `din` before rising edge n (with `sleep` low and `rst_n` high) is captured at edge n and appears on every output after edge n+1. After edge n alone, the outputs still show the word captured at edge n-1.
- R2: Segment line `seg_sw[k]`, for k from 0 to 30, is 1 exactly when the upper field `din[11:7]` of the shown word is greater than k. The asserted segments therefore always form a contiguous run starting at bit 0.
- R3: `bin_sw[6:0]` equals the low field `din[6:0]` of the shown word, bit for bit.
- R4: `wt_true` equals 128 times the number of asserted segments plus the value of `bin_sw`. Word 0xFFF gives 4095 and word 0x000 gives 0.
- R5: While awake, `wt_true + wt_comp` is always 4095.
- R6: Midscale word 0x800 gives 16 asserted segments, `bin_sw` = 0, `wt_true` = 2048 and `wt_comp` = 2047. The two legs are balanced to within one LSB.
- R7: While `sleep` is 1, all 31 segment lines, all 7 binary lines and both weights are 0, in the same cycle in which `sleep` is seen high.
- R8: While `sleep` is 1, neither pipeline stage changes. After `sleep` returns to 0, the outputs first show the word that was shown before sleep. After the next edge they show the word that was captured before sleep.
- R9: A rising edge with `rst_n` low clears both stages to code zero: no segments, `bin_sw` = 0, `wt_true` = 0, `wt_comp` = 4095. After release, the first edge still shows code zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears both stages |
| sleep | input | 1 | Power-down request, active high; silences outputs and freezes the pipeline |
| din | input | 12 | Code word, bit 11 most significant |
| seg_sw | output | 31 | Thermometer unit-segment switch controls |
| bin_sw | output | 7 | Binary-weighted switch controls |
| wt_true | output | 12 | Weight of the true output leg in LSB units |
| wt_comp | output | 12 | Weight of the complementary leg in LSB units |

## Verification
The hardest situation to reach from the ports is sleep recovery. Checking it needs a point where the two stages hold different words, the sleep window swallows new input words, and the release then shows both held words in order. The stimulus first streams two distinct words so that each stage holds its own word. It raises sleep while changing `din` on every cycle of the window, then drops sleep and follows the outputs edge by edge. A reset in the middle of a full-scale stream is checked the same way, one edge at a time after release. This shows that both stages were cleared and not only the output stage.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

   // Default geometry of the converter front end.
   localparam int unsigned DEF_DATA_W   = 12;
   localparam int unsigned DEF_SEG_BITS = 5;

   // Implementation choice for the thermometer expansion.
   typedef enum logic {
      DEC_COMPARE = 1'b0,   // one magnitude comparator per segment
      DEC_SHIFT   = 1'b1    // shifted all-ones mask
   } dec_style_e;

endpackage

// File: rtl/segdac_capture.sv
// First pipeline stage: holds the raw code word.
module segdac_capture #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (!hold)
         q <= d;
   end

   // R1: an awake edge loads the presented word
   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> q == $past(d));

   // R8: a frozen edge leaves the stage untouched
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));

   // R9: a reset edge leaves code zero behind
   p_clear_r9: assert property (@(posedge clk)
      !rst_n |=> q == '0);

endmodule

// File: rtl/segdac_thermo.sv
// Thermometer expansion of the upper code field.
module segdac_thermo
   import segdac_pkg::*;
#(
   parameter int unsigned SEG_BITS  = DEF_SEG_BITS,
   parameter dec_style_e  DEC_STYLE = DEC_COMPARE,
   localparam int unsigned NSEG     = (2 ** SEG_BITS) - 1
) (
   input  logic [SEG_BITS-1:0] field,
   output logic [NSEG-1:0]     seg
);

   if (DEC_STYLE == DEC_SHIFT) begin : g_shift
      // Ones shifted up by the field, then inverted: low 'field' bits set.
      assign seg = ~({NSEG{1'b1}} << field);
   end else begin : g_compare
      for (genvar k = 0; k < NSEG; k++) begin : g_seg
         assign seg[k] = (field > SEG_BITS'(k));
      end
   end

   // R2: the number of lit segments equals the field value
   always_comb begin
      p_count_r2: assert ($countones(seg) == int'(field))
         else $error("thermometer population differs from field");
   end

endmodule

// File: rtl/segdac_switch_reg.sv
// Second pipeline stage: decodes the held word and registers the switch controls.
module segdac_switch_reg
   import segdac_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned SEG_BITS  = DEF_SEG_BITS,
   parameter dec_style_e  DEC_STYLE = DEC_COMPARE,
   localparam int unsigned LSB_W    = DATA_W - SEG_BITS,
   localparam int unsigned NSEG     = (2 ** SEG_BITS) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [DATA_W-1:0] code,
   output logic [NSEG-1:0]   seg_q,
   output logic [LSB_W-1:0]  bin_q
);

   logic [NSEG-1:0] seg_d;

   segdac_thermo #(
      .SEG_BITS  (SEG_BITS),
      .DEC_STYLE (DEC_STYLE)
   ) i_thermo (
      .field (code[DATA_W-1 -: SEG_BITS]),
      .seg   (seg_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q <= '0;
         bin_q <= '0;
      end else if (!hold) begin
         seg_q <= seg_d;
         bin_q <= code[LSB_W-1:0];
      end
   end

   // R8: switch state is frozen while held
   p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(seg_q) && $stable(bin_q));

   // R3: binary lines follow the low field of the word held one edge earlier
   p_bin_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> bin_q == $past(code[LSB_W-1:0]));

endmodule

// File: rtl/segdac_weigh.sv
// Output gating and integer weights of the two current legs.
module segdac_weigh #(
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned SEG_BITS = 5,
   localparam int unsigned LSB_W   = DATA_W - SEG_BITS,
   localparam int unsigned NSEG    = (2 ** SEG_BITS) - 1,
   localparam int unsigned SEG_WT  = 2 ** LSB_W
) (
   input  logic              sleep,
   input  logic [NSEG-1:0]   seg_q,
   input  logic [LSB_W-1:0]  bin_q,
   output logic [NSEG-1:0]   seg_sw,
   output logic [LSB_W-1:0]  bin_sw,
   output logic [DATA_W-1:0] wt_true,
   output logic [DATA_W-1:0] wt_comp
);

   localparam logic [DATA_W-1:0] FULL = '1;

   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] true_raw;

   // Sum the unit cells one by one, as the analog array would.
   always_comb begin
      acc = '0;
      for (int k = 0; k < NSEG; k++) begin
         if (seg_q[k])
            acc = acc + DATA_W'(SEG_WT);
      end
      true_raw = acc + {{SEG_BITS{1'b0}}, bin_q};
   end

   assign seg_sw  = sleep ? '0 : seg_q;
   assign bin_sw  = sleep ? '0 : bin_q;
   assign wt_true = sleep ? '0 : true_raw;
   assign wt_comp = sleep ? '0 : (FULL - true_raw);

endmodule

// File: rtl/segdac_front.sv
// Two-stage segmented front end: raw capture, then decoded switch register.
module segdac_front
   import segdac_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned SEG_BITS  = DEF_SEG_BITS,
   parameter dec_style_e  DEC_STYLE = DEC_COMPARE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sleep,
   input  logic [DATA_W-1:0]            din,
   output logic [(2**SEG_BITS)-2:0]     seg_sw,
   output logic [DATA_W-SEG_BITS-1:0]   bin_sw,
   output logic [DATA_W-1:0]            wt_true,
   output logic [DATA_W-1:0]            wt_comp
);

   localparam int unsigned LSB_W = DATA_W - SEG_BITS;
   localparam int unsigned NSEG  = (2 ** SEG_BITS) - 1;
   localparam logic [DATA_W:0] FULL_X = {1'b0, {DATA_W{1'b1}}};

   initial begin : param_chk
      assert (SEG_BITS >= 1 && SEG_BITS < DATA_W)
         else $fatal(1, "SEG_BITS must lie between 1 and DATA_W-1");
      assert (SEG_BITS <= 8)
         else $fatal(1, "SEG_BITS above 8 makes an oversized segment array");
   end

   logic [DATA_W-1:0] code_q;
   logic [NSEG-1:0]   seg_q;
   logic [LSB_W-1:0]  bin_q;

   segdac_capture #(.W(DATA_W)) i_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (sleep),
      .d     (din),
      .q     (code_q)
   );

   segdac_switch_reg #(
      .DATA_W    (DATA_W),
      .SEG_BITS  (SEG_BITS),
      .DEC_STYLE (DEC_STYLE)
   ) i_switch (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (sleep),
      .code  (code_q),
      .seg_q (seg_q),
      .bin_q (bin_q)
   );

   segdac_weigh #(
      .DATA_W   (DATA_W),
      .SEG_BITS (SEG_BITS)
   ) i_weigh (
      .sleep   (sleep),
      .seg_q   (seg_q),
      .bin_q   (bin_q),
      .seg_sw  (seg_sw),
      .bin_sw  (bin_sw),
      .wt_true (wt_true),
      .wt_comp (wt_comp)
   );

   // R2: the lit segments form one run from bit 0
   p_thermo_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_sw >> 1) & ~seg_sw) == '0);

   // R5: the two legs always add up to full scale minus one LSB
   p_leg_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep |-> ({1'b0, wt_true} + {1'b0, wt_comp}) == FULL_X);

   // R7: sleep silences every switch and both weights
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (seg_sw == '0) && (bin_sw == '0) && (wt_true == '0) && (wt_comp == '0));

endmodule

// File: tb/test_segdac_front.sv
module test_segdac_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep = 1'b0;
   logic [11:0] din = 12'hFFF;
   logic [30:0] seg_sw;
   logic [6:0]  bin_sw;
   logic [11:0] wt_true;
   logic [11:0] wt_comp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   segdac_front i_segdac_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .din     (din),
      .seg_sw  (seg_sw),
      .bin_sw  (bin_sw),
      .wt_true (wt_true),
      .wt_comp (wt_comp)
   );

   // One rising edge, then settle on the falling edge.
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_code(string req, logic [11:0] code);
      logic [31:0] mask;
      logic [30:0] e_seg;
      logic [6:0]  e_bin;
      logic [11:0] e_t, e_c;
      mask  = (32'd1 << code[11:7]) - 32'd1;
      e_seg = mask[30:0];
      e_bin = code[6:0];
      e_t   = 12'(int'(code[11:7]) * 128 + int'(code[6:0]));
      e_c   = 12'd4095 - e_t;
      n_cmp++;
      if (seg_sw !== e_seg || bin_sw !== e_bin || wt_true !== e_t || wt_comp !== e_c) begin
         n_bad++;
         $display("FAIL %s: got seg=%h bin=%h true=%0d comp=%0d, expected seg=%h bin=%h true=%0d comp=%0d",
                  req, seg_sw, bin_sw, wt_true, wt_comp, e_seg, e_bin, e_t, e_c);
      end
   endtask

   task automatic check_quiet(string req);
      n_cmp++;
      if (seg_sw !== '0 || bin_sw !== '0 || wt_true !== '0 || wt_comp !== '0) begin
         n_bad++;
         $display("FAIL %s: got seg=%h bin=%h true=%0d comp=%0d, expected all zero",
                  req, seg_sw, bin_sw, wt_true, wt_comp);
      end
   endtask

   task automatic flush(logic [11:0] code);
      din = code;
      tick();
      tick();
   endtask

   // R9: reset held with a full-scale input
   task automatic t_reset_state();
      rst_n = 1'b0;
      din   = 12'hFFF;
      tick(); tick(); tick();
      check_code("R9 reset state", 12'h000);
      rst_n = 1'b1;
   endtask

   // R1: one edge is not enough, two edges are
   task automatic t_latency();
      flush(12'h000);
      din = 12'hA5C;
      tick();
      check_code("R1 after first edge", 12'h000);
      tick();
      check_code("R1 after second edge", 12'hA5C);
   endtask

   // R4 and R6: transfer corners
   task automatic t_corners();
      flush(12'hFFF); check_code("R4 all ones", 12'hFFF);
      flush(12'h000); check_code("R4 all zeros", 12'h000);
      flush(12'h800); check_code("R6 midscale", 12'h800);
      n_cmp++;
      if (wt_true !== 12'd2048 || wt_comp !== 12'd2047) begin
         n_bad++;
         $display("FAIL R6 midscale legs: got true=%0d comp=%0d, expected true=2048 comp=2047",
                  wt_true, wt_comp);
      end
      flush(12'h7FF); check_code("R4 below midscale", 12'h7FF);
      flush(12'h07F); check_code("R3 low field only", 12'h07F);
      flush(12'h080); check_code("R2 single segment", 12'h080);
   endtask

   // R2, R3, R5: back-to-back words sweeping every upper field value
   task automatic t_stream();
      logic [11:0] words [34];
      for (int u = 0; u < 32; u++)
         words[u] = {5'(u), 7'((u * 37 + 5) & 32'h7F)};
      words[32] = 12'h07F;
      words[33] = 12'hF80;
      for (int i = 0; i < 34; i++) begin
         din = words[i];
         tick();
         if (i > 0)
            check_code("R2/R3/R5 stream", words[i-1]);
      end
      tick();
      check_code("R5 stream tail", words[33]);
   endtask

   // R7 and R8: quiet outputs, frozen stages, ordered recovery
   task automatic t_sleep();
      din = 12'h3C1;          // word A
      tick();
      din = 12'hC3E;          // word B
      tick();
      check_code("R8 pre-sleep", 12'h3C1);
      sleep = 1'b1;
      din   = 12'h111;
      #1;
      check_quiet("R7 sleep same cycle");
      tick();
      check_quiet("R7 sleep after edge");
      din = 12'h222;
      tick();
      check_quiet("R7 sleep second edge");
      sleep = 1'b0;
      din   = 12'h5A5;        // word E
      #1;
      check_code("R8 resume shows held output word", 12'h3C1);
      tick();
      check_code("R8 resume shows held captured word", 12'hC3E);
      tick();
      check_code("R8 new word after resume", 12'h5A5);
   endtask

   // R9: reset in the middle of a stream clears both stages
   task automatic t_mid_reset();
      flush(12'hFFF);
      check_code("R9 pre-reset", 12'hFFF);
      rst_n = 1'b0;
      tick();
      check_code("R9 reset edge", 12'h000);
      rst_n = 1'b1;
      din   = 12'h456;
      tick();
      check_code("R9 first stage was cleared", 12'h000);
      tick();
      check_code("R9 stream restarts", 12'h456);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      @(negedge clk);
      t_reset_state();
      t_latency();
      t_corners();
      t_stream();
      t_sleep();
      t_mid_reset();
      done = 1'b1;
      report();
   end

   initial begin
      #200000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog: got no completion, expected completion");
         report();
      end
   end

endmodule